// File: doc/BRIEF.md
# Contention Address Arbiter

This block lets up to eight controllers share one data channel and one command/indicate channel. They resolve contention through four open-drain slots carried on a common serial frame, where any driver pulling a slot to 0 wins over every driver that releases it. Three slots carry a race of local addresses, sent most significant bit first. A fourth slot is a shared flag: it reads 1 when the channels are free and 0 when they are occupied.

A request exists while arbitration is enabled and the local command code is anything other than the deactivation code 1111. With a request pending, the block waits for a frame in which the free flag reads 1. In the next frame it drives its address one bit per slot and reads each slot back. The first bit that reads back differently ends the attempt. If all bits read back as driven, the block has won: it raises `granted` and pulls the flag slot low in every later frame. Writing 1111, or clearing the enable, withdraws the request and releases the flag slot.

The frame timing is presented one slot at a time on `slot_vld`/`slot_idx`, with the resolved line value on `slot_rx`. The block's own drive appears on `slot_tx` combinationally, in the same cycle.

Top module: `cont_arbiter`

## Requirements
- R1: After a synchronous active-low reset, `granted` is 0 and `slot_tx` is 1 (released) for every slot index.
- R2: A request exists only while `arb_en` is 1 and `cmd` differs from 4'b1111. Without a request, `slot_tx` stays 1 and `granted` stays 0.
- R3: With a request pending and no race or grant in progress, a `slot_vld` cycle with `slot_idx` = 3 (the free-flag slot) and `slot_rx` = 1 starts a race in the following frame. If that slot reads 0, no race starts.
- R4: During a race, `slot_tx` equals `addr[2]` at `slot_idx` 0, `addr[1]` at `slot_idx` 1 and `addr[0]` at `slot_idx` 2.
- R5: If a race slot reads back a value different from the bit driven, the attempt ends at once. The remaining slots of that frame are driven 1, no grant follows, and a new attempt waits for a later frame in which the free flag reads 1.
- R6: When all three race slots read back correctly, `granted` is 1 from the cycle after the `slot_idx` 2 sample. While `granted` is 1, `slot_tx` is 0 at `slot_idx` 3.
- R7: When two controllers race, the lower address wins: the block loses exactly when a rival's address is numerically lower than its own.
- R8: When the request disappears (`cmd` = 4'b1111 or `arb_en` = 0), `granted` falls on the next clock, the free-flag slot is released, and any race in progress is abandoned.
- R9: Cycles with `slot_vld` = 0 never start a race, advance a race or raise `granted`, whatever `slot_idx` and `slot_rx` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arb_en | input | 1 | Contention arbitration enable |
| cmd | input | 4 | Local command code; 4'b1111 withdraws the request |
| addr | input | 3 | Local arbitration address |
| slot_vld | input | 1 | A contention slot is present this cycle |
| slot_idx | input | 2 | Slot number: 0..2 address slots (MSB first), 3 free flag |
| slot_rx | input | 1 | Resolved wired-AND value of the current slot |
| slot_tx | output | 1 | Local open-drain drive for the current slot (1 = release) |
| granted | output | 1 | Channels held by this controller |

## Verification
`slot_tx` is combinational from the registered state and the slot number, so it is due in the same cycle a slot is presented. The bench checks it after driving the slot and before the rising edge, and only then returns the wired-AND of that drive and the rival pulls on `slot_rx`. `granted` is registered and changes one clock after the third address sample or after a withdrawal. The bench therefore checks it on the falling edge that follows, before each slot and after each request change. A bench model steps through the same frame and slot sequence and predicts every value, using a racing rival whose address and dropout follow the lowest-address rule.

// File: rtl/cont_arb_pkg.sv
// Package: shared state encoding for the contention address arbiter.
// Assumes: a single-driver state register inside the arbiter FSM.
package cont_arb_pkg;

    // Arbitration progress of the local controller.
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,   // no race, all slots released
        ARB_RACE = 2'd1,   // address race in the current frame
        ARB_HELD = 2'd2    // won; channels claimed
    } arb_state_e;

endpackage

// File: rtl/cont_arb_req.sv
// Module: cont_arb_req
// Decodes whether an access request is pending: arbitration must be
// enabled and the local command must not be the deactivation code.
// Assumes: the command and enable are stable registers of the host.
module cont_arb_req #(
    parameter int          CMD_W = 4,
    parameter logic [CMD_W-1:0] DEACT_CODE = '1
) (
    input  logic             arb_en,
    input  logic [CMD_W-1:0] cmd,
    output logic             req
);

    // Request qualifier: enabled and not deactivating.
    always_comb begin
        req = arb_en && (cmd != DEACT_CODE);
    end

endmodule

// File: rtl/cont_arb_drive.sv
// Module: cont_arb_drive
// Chooses the open-drain value for the slot being presented: address
// bits (MSB first) in race slots during a race, a low busy flag in the
// flag slot while holding the channels, and release (1) otherwise.
// Assumes: slot indices 0..ADDR_W-1 are address slots, ADDR_W is the flag.
module cont_arb_drive
    import cont_arb_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int IDX_W  = $clog2(ADDR_W + 1)
) (
    input  arb_state_e        state,
    input  logic [IDX_W-1:0]  slot_idx,
    input  logic [ADDR_W-1:0] addr,
    output logic              slot_tx
);

    localparam int NUM_SLOTS = ADDR_W + 1;
    localparam logic [IDX_W-1:0] FLAG_IDX = IDX_W'(ADDR_W);

    logic [NUM_SLOTS-1:0] race_pat;

    // Map address bits onto slots, most significant bit in slot 0.
    generate
        for (genvar k = 0; k < ADDR_W; k++) begin : g_slot_map
            assign race_pat[k] = addr[ADDR_W-1-k];
        end
    endgenerate
    assign race_pat[ADDR_W] = 1'b1;

    // Slot drive selection per state and slot number.
    always_comb begin
        slot_tx = 1'b1;
        if (int'(slot_idx) < NUM_SLOTS) begin
            unique case (state)
                ARB_RACE: slot_tx = race_pat[slot_idx];
                ARB_HELD: slot_tx = (slot_idx == FLAG_IDX) ? 1'b0 : 1'b1;
                default:  slot_tx = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/cont_arb_fsm.sv
// Module: cont_arb_fsm
// Tracks the arbitration state across frames: arms on a free flag,
// compares each driven address bit with the read-back value, claims
// the channels on a clean race and drops everything when the request
// disappears.
// Assumes: slots arrive in order 0..ADDR_W within a frame.
module cont_arb_fsm
    import cont_arb_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int IDX_W  = $clog2(ADDR_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             slot_vld,
    input  logic [IDX_W-1:0] slot_idx,
    input  logic             slot_rx,
    input  logic             slot_tx,
    output arb_state_e       state,
    output logic             granted
);

    localparam logic [IDX_W-1:0] FLAG_IDX = IDX_W'(ADDR_W);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(ADDR_W - 1);

    arb_state_e state_nxt;

    // Next-state decision for the current slot.
    always_comb begin
        state_nxt = state;
        if (!req) begin
            state_nxt = ARB_IDLE;
        end else if (slot_vld) begin
            unique case (state)
                ARB_IDLE: if (slot_idx == FLAG_IDX && slot_rx) state_nxt = ARB_RACE;
                ARB_RACE: begin
                    if (slot_idx == FLAG_IDX)      state_nxt = ARB_IDLE;
                    else if (slot_rx != slot_tx)   state_nxt = ARB_IDLE;
                    else if (slot_idx == LAST_BIT) state_nxt = ARB_HELD;
                end
                ARB_HELD: state_nxt = ARB_HELD;
                default:  state_nxt = ARB_IDLE;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ARB_IDLE;
        else        state <= state_nxt;
    end

    assign granted = (state == ARB_HELD);

    // R6
    grant_after_clean_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(granted) |-> $past(state == ARB_RACE && slot_vld && slot_idx == LAST_BIT && slot_rx == slot_tx));

    // R5
    mismatch_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_RACE && slot_vld && slot_idx != FLAG_IDX && slot_rx != slot_tx) |=> !granted);

    // R8
    withdraw_drops_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !granted);

    // R9
    idle_slot_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_vld |=> !$rose(granted));

endmodule

// File: rtl/cont_arbiter.sv
// Module: cont_arbiter (top)
// Contention address arbiter for a shared channel pair on a wired-AND
// serial frame. Joins the request decode, the state tracker and the
// slot drive selection.
// Assumes: slot_rx is the resolved line value of the slot whose drive
// is on slot_tx in the same cycle.
module cont_arbiter
    import cont_arb_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CMD_W  = 4,
    parameter logic [CMD_W-1:0] DEACT_CODE = '1,
    localparam int IDX_W = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arb_en,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              slot_vld,
    input  logic [IDX_W-1:0]  slot_idx,
    input  logic              slot_rx,
    output logic              slot_tx,
    output logic              granted
);

    localparam logic [IDX_W-1:0] FLAG_IDX = IDX_W'(ADDR_W);

    logic       req;
    arb_state_e state;

    cont_arb_req #(.CMD_W(CMD_W), .DEACT_CODE(DEACT_CODE)) u_req (
        .arb_en (arb_en),
        .cmd    (cmd),
        .req    (req)
    );

    cont_arb_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .slot_vld (slot_vld),
        .slot_idx (slot_idx),
        .slot_rx  (slot_rx),
        .slot_tx  (slot_tx),
        .state    (state),
        .granted  (granted)
    );

    cont_arb_drive #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_drive (
        .state    (state),
        .slot_idx (slot_idx),
        .addr     (addr),
        .slot_tx  (slot_tx)
    );

    // R6
    held_pulls_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && slot_vld && slot_idx == FLAG_IDX) |-> !slot_tx);

    // R2
    no_req_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && $past(!req)) |-> slot_tx);

endmodule

// File: tb/cont_arbiter_tb.sv
`timescale 1ns/1ps
module cont_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arb_en = 1'b0;
    logic [3:0] cmd = 4'hF;
    logic [2:0] addr = 3'd0;
    logic       slot_vld = 1'b0;
    logic [1:0] slot_idx = 2'd0;
    logic       slot_rx = 1'b1;
    logic       slot_tx;
    logic       granted;

    int vectors = 0;
    int fails = 0;
    int m_state = 0;   // 0 idle, 1 race, 2 held (bench model)
    bit done = 0;

    always #2.5 clk = ~clk;

    cont_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .cmd(cmd), .addr(addr),
        .slot_vld(slot_vld), .slot_idx(slot_idx), .slot_rx(slot_rx),
        .slot_tx(slot_tx), .granted(granted)
    );

    function automatic bit req_now();
        return arb_en && (cmd != 4'hF);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Change the request inputs between frames; R8 on withdrawal.
    task automatic set_req(input logic e, input logic [3:0] c);
        @(negedge clk);
        slot_vld = 1'b0;
        arb_en = e;
        cmd = c;
        if (!req_now()) m_state = 0;
        @(negedge clk);
        check(req_now() ? "R8 grant kept" : "R8 withdraw", granted, m_state == 2);
    endtask

    // One frame of four slots with optional rival and external busy pull.
    task automatic do_frame(input bit ext_busy, input bit rival_on, input logic [2:0] ra);
        bit rin;
        logic exp_tx, ext_bit, rx;
        string tag;
        rin = rival_on && (m_state != 2);
        for (int k = 0; k < 4; k++) begin
            int gap;
            gap = $urandom_range(0, 1);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                slot_vld = 1'b0;
                slot_idx = 2'($urandom);
                slot_rx = 1'($urandom);
                @(negedge clk);
                check("R9 gap", granted, m_state == 2);
            end
            @(negedge clk);
            slot_vld = 1'b1;
            slot_idx = 2'(k);
            check("R6 grant", granted, m_state == 2);
            if (k < 3) begin
                exp_tx = (m_state == 1) ? addr[2-k] : 1'b1;
                ext_bit = rin ? ra[2-k] : 1'b1;
                tag = (m_state == 1) ? "R4 race bit" : (req_now() ? "R5 released" : "R2 no request");
            end else begin
                exp_tx = (m_state == 2) ? 1'b0 : 1'b1;
                ext_bit = !(ext_busy || rin);
                tag = (m_state == 2) ? "R6 busy flag" : (req_now() ? "R5 released" : "R2 no request");
            end
            #1;
            check(tag, slot_tx, exp_tx);
            rx = slot_tx & ext_bit;
            slot_rx = rx;
            if (k < 3) begin
                if (rin && ra[2-k] && !rx) rin = 0;
                if (m_state == 1) begin
                    if (rx != exp_tx) m_state = 0;
                    else if (k == 2) m_state = 2;
                end
            end else begin
                if (m_state == 0 && req_now() && rx) m_state = 1;
            end
        end
        @(negedge clk);
        slot_vld = 1'b0;
        check("R6 grant end", granted, m_state == 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5151));
        arb_en = 1'b1;
        cmd = 4'h0;
        repeat (4) @(negedge clk);
        check("R1 reset grant", granted, 1'b0);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            slot_idx = 2'(k);
            #1;
            check("R1 reset drive", slot_tx, 1'b1);
        end

        // R2: no request while disabled, even with free flag.
        set_req(1'b0, 4'h0);
        addr = 3'd4;
        do_frame(0, 0, 3'd0);
        do_frame(0, 0, 3'd0);
        check("R2 no grant", granted, 1'b0);

        // R3: busy flag does not arm; free flag arms; R4/R6 clean race wins.
        set_req(1'b1, 4'h3);
        do_frame(1, 0, 3'd0);
        check("R3 busy no arm", m_state == 0, 1'b1);
        do_frame(0, 0, 3'd0);
        do_frame(0, 0, 3'd0);
        check("R6 won", granted, 1'b1);
        do_frame(0, 0, 3'd0);
        set_req(1'b1, 4'hF);
        check("R8 released", granted, 1'b0);

        // R7/R5: rival with lower address wins; then retry without rival.
        set_req(1'b1, 4'h1);
        addr = 3'd5;
        do_frame(0, 0, 3'd0);
        do_frame(0, 1, 3'd3);
        check("R7 lower rival wins", granted, 1'b0);
        do_frame(0, 0, 3'd0);
        do_frame(0, 0, 3'd0);
        check("R5 retry wins", granted, 1'b1);
        set_req(1'b0, 4'h1);

        // R7: own lower address beats a higher rival.
        set_req(1'b1, 4'h2);
        addr = 3'd2;
        do_frame(0, 0, 3'd0);
        do_frame(0, 1, 3'd6);
        check("R7 own lower wins", granted, 1'b1);

        // R8: withdrawal abandons a race in progress.
        set_req(1'b0, 4'h2);
        set_req(1'b1, 4'h2);
        do_frame(0, 0, 3'd0);
        set_req(1'b1, 4'hF);
        do_frame(0, 0, 3'd0);
        check("R8 race abandoned", granted, 1'b0);

        // Random frames.
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 7) == 0) begin
                logic e;
                logic [3:0] c;
                e = ($urandom_range(0, 7) != 0);
                c = ($urandom_range(0, 3) == 0) ? 4'hF : 4'($urandom);
                set_req(e, c);
            end
            if ($urandom_range(0, 15) == 0 && m_state == 0) addr = 3'($urandom);
            do_frame($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, 3'($urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule